// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block drains a circular list of transmit descriptors held in system memory and turns the buffers they point to into a byte stream. Each descriptor is two 32-bit words. The word at the descriptor's address holds the buffer's byte address. The word four bytes above it is a combined control and status word. Software fills the descriptors, clears their ownership flag, loads the ring start address while the block is idle, and pulses `start`. The block then walks the ring. For every descriptor it owns, it reads the buffer one word at a time and sends the bytes out with a valid/ready handshake. It then writes the control word back with the ownership flag set, which returns the descriptor to software.

The walk stops when the block reads a control word whose ownership flag is already set. If that descriptor sits between frames, the block simply goes idle. If it interrupts a frame, the block marks that descriptor as exhausted, closes the output frame with an error beat, and goes idle. A `halt` request lets the current frame finish, then stops before the next descriptor is fetched. The fetch pointer keeps its position across runs, so a later `start` resumes where the ring stopped.

Memory is a simple port with a fixed latency. A read issued in one cycle returns its data in the next cycle. A write completes at the clock edge on which it is presented. Buffer addresses must be word aligned.

Top module: `txring_dma`

## Requirements
- R1: After reset, `go`, `tx_valid`, `mem_rd` and `mem_wr` are all low, and the fetch pointer and ring base are both 0.
- R2: On `start` while idle, the block reads the control word at pointer+4. If bit 31 of that word is clear, it reads the buffer address at the pointer. It then sends as many bytes as bits 10:0 of the control word give, in ascending address order, taking the lowest byte of each 32-bit word first.
- R3: `tx_last` is high with the final byte of a buffer whose control bit 15 is set, and it is low on every other data byte.
- R4: `tx_nocrc` equals bit 16 of the control word of the buffer whose byte is being sent.
- R5: After the last byte of a buffer, the block writes that buffer's control word back to pointer+4 with bit 31 set and every other bit unchanged.
- R6: After a write-back, the next descriptor is at the ring base if control bit 30 was set, and otherwise at the pointer plus 8.
- R7: A descriptor with bit 31 set, met between frames, ends the run: no write, no byte, and `go` drops.
- R8: A `start` while idle whose first descriptor already has bit 31 set causes no byte and no write. `go` is back to 0 within 3 cycles, and the pointer does not move.
- R9: A descriptor with bit 31 set, met inside a frame, gets its control word rewritten with bit 27 set. The block then sends one beat with data 0, `tx_last`=1 and `tx_err`=1, and goes idle with the pointer still on that descriptor.
- R10: A `halt` pulse while busy lets the frame in progress finish, including its write-back. The block then goes idle without fetching the next descriptor, and a later `start` continues from that descriptor.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold steady into the next cycle.
- R12: A `base_wr` pulse while idle loads `ring_base` as both the ring base and the fetch pointer.
- R13: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Ring start byte address |
| base_wr | input | 1 | Load `ring_base` (honoured only while idle) |
| start | input | 1 | Begin walking the ring |
| halt | input | 1 | Stop at the next frame boundary |
| go | output | 1 | High while the block is busy |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after `mem_rd` |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Last byte of a frame |
| tx_nocrc | output | 1 | Frame must not get a CRC appended |
| tx_err | output | 1 | Frame aborted because descriptors ran out |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
A wrong fetch pointer shows up at the very next write-back, whose address or data no longer matches the model's. A wrong byte counter or word position corrupts a data byte or moves `tx_last` within the same buffer. A stale ownership or frame flag shows as a missing or extra error beat, or as `go` falling too early or too late, within a few cycles of the descriptor that exposes it. Every handshaken byte and every memory write is compared against a behavioural walk of the ring in the cycle it occurs, so a divergence is reported at its first visible effect.

// File: rtl/txring_pkg.sv
package txring_pkg;
  localparam int LEN_W     = 11;
  localparam int EOF_BIT   = 15;
  localparam int NOCRC_BIT = 16;
  localparam int EXH_BIT   = 27;
  localparam int WRAP_BIT  = 30;
  localparam int USED_BIT  = 31;
  localparam int CW        = 32;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CTL_REQ, ST_CTL_CHK, ST_ADR_REQ, ST_ADR_CAP,
    ST_DAT_REQ, ST_DAT_CAP, ST_SEND, ST_WB, ST_ABT_WB, ST_ABT_TX
  } tx_state_e;

  function automatic logic [LEN_W-1:0] ctl_len(input logic [CW-1:0] c);
    return c[LEN_W-1:0];
  endfunction

  function automatic logic [CW-1:0] ctl_done(input logic [CW-1:0] c);
    logic [CW-1:0] r;
    r = c;
    r[USED_BIT] = 1'b1;
    return r;
  endfunction

  function automatic logic [CW-1:0] ctl_exhaust(input logic [CW-1:0] c);
    logic [CW-1:0] r;
    r = c;
    r[EXH_BIT] = 1'b1;
    return r;
  endfunction

  // bytes to take from the next word given the bytes still owed
  function automatic logic [2:0] word_beats(input logic [LEN_W-1:0] remain);
    return (remain >= LEN_W'(4)) ? 3'd4 : remain[2:0];
  endfunction
endpackage

// File: rtl/txring_ptr.sv
module txring_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_load,
  input  logic [AW-1:0] base_in,
  input  logic          advance,
  input  logic          wrap,
  output logic [AW-1:0] ptr
);
  localparam int DESC_BYTES = 8;

  logic [AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr    <= '0;
    end else if (base_load) begin
      base_q <= base_in;
      ptr    <= base_in;
    end else if (advance) begin
      ptr <= wrap ? base_q : ptr + AW'(DESC_BYTES);
    end
  end

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    advance && wrap && !base_load |=> ptr == base_q);
  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !wrap && !base_load |=> ptr == $past(ptr) + AW'(DESC_BYTES));
endmodule

// File: rtl/txring_ser.sv
module txring_ser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] word,
  input  logic [2:0]  count,
  input  logic        ready,
  output logic        valid,
  output logic [7:0]  data,
  output logic        fire,
  output logic        word_done
);
  logic [31:0] sh_q;
  logic [2:0]  cnt_q;

  assign valid     = (cnt_q != 3'd0);
  assign data      = sh_q[7:0];
  assign fire      = valid && ready;
  assign word_done = fire && (cnt_q == 3'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sh_q  <= word;
      cnt_q <= count;
    end else if (fire) begin
      sh_q  <= {8'h00, sh_q[31:8]};
      cnt_q <= cnt_q - 3'd1;
    end
  end

  assert_ser_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready && !load |=> valid && $stable(data));
endmodule

// File: rtl/txring_dma.sv
module txring_dma #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          base_wr,
  input  logic          start,
  input  logic          halt,
  output logic          go,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          tx_nocrc,
  output logic          tx_err,
  input  logic          tx_ready
);
  import txring_pkg::*;

  localparam int CTL_OFS = 4;
  localparam int WORD_B  = 4;

  tx_state_e        state_q, state_d;
  logic [CW-1:0]    ctrl_q;
  logic [AW-1:0]    buf_q;
  logic [LEN_W-1:0] remain_q;
  logic             in_frame_q, halt_q;
  logic [AW-1:0]    ptr;

  // named internal events
  logic stop_boundary, hit_used, wb_fire, abt_fire;
  logic ser_valid, ser_fire, ser_done;
  logic [7:0] ser_data;

  assign stop_boundary = (state_q == ST_CTL_REQ) && (halt_q || halt) && !in_frame_q;
  assign hit_used      = (state_q == ST_CTL_CHK) && mem_rdata[USED_BIT];
  assign wb_fire       = (state_q == ST_WB);
  assign abt_fire      = (state_q == ST_ABT_TX) && tx_ready;

  txring_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .base_load(base_wr && state_q == ST_IDLE), .base_in(ring_base),
    .advance(wb_fire), .wrap(ctrl_q[WRAP_BIT]), .ptr(ptr)
  );

  txring_ser u_ser (
    .clk(clk), .rst_n(rst_n),
    .load(state_q == ST_DAT_CAP), .word(mem_rdata), .count(word_beats(remain_q)),
    .ready(tx_ready), .valid(ser_valid), .data(ser_data),
    .fire(ser_fire), .word_done(ser_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start) state_d = ST_CTL_REQ;
      ST_CTL_REQ: state_d = stop_boundary ? ST_IDLE : ST_CTL_CHK;
      ST_CTL_CHK: begin
        if (!mem_rdata[USED_BIT]) state_d = ST_ADR_REQ;
        else if (in_frame_q)      state_d = ST_ABT_WB;
        else                      state_d = ST_IDLE;
      end
      ST_ADR_REQ: state_d = ST_ADR_CAP;
      ST_ADR_CAP: state_d = (ctl_len(ctrl_q) == '0) ? ST_WB : ST_DAT_REQ;
      ST_DAT_REQ: state_d = ST_DAT_CAP;
      ST_DAT_CAP: state_d = ST_SEND;
      ST_SEND:    if (ser_done) state_d = (remain_q == LEN_W'(1)) ? ST_WB : ST_DAT_REQ;
      ST_WB:      state_d = ST_CTL_REQ;
      ST_ABT_WB:  state_d = ST_ABT_TX;
      ST_ABT_TX:  if (tx_ready) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ctrl_q     <= '0;
      buf_q      <= '0;
      remain_q   <= '0;
      in_frame_q <= 1'b0;
      halt_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE) halt_q <= 1'b0;
      else if (halt)          halt_q <= 1'b1;
      if (state_q == ST_CTL_CHK) ctrl_q <= mem_rdata;
      if (state_q == ST_ADR_CAP) begin
        remain_q <= ctl_len(ctrl_q);
      end
      if (state_q == ST_ADR_REQ) buf_q <= buf_q;
      if (state_q == ST_ADR_CAP) buf_q <= mem_rdata[AW-1:0];
      else if (ser_done)         buf_q <= buf_q + AW'(WORD_B);
      if (ser_fire) remain_q <= remain_q - LEN_W'(1);
      if (wb_fire) in_frame_q <= !ctrl_q[EOF_BIT];
      else if (state_q == ST_ABT_WB) in_frame_q <= 1'b0;
    end
  end

  // memory port
  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state_q)
      ST_CTL_REQ: begin mem_rd = !stop_boundary; mem_addr = ptr + AW'(CTL_OFS); end
      ST_ADR_REQ: begin mem_rd = 1'b1; mem_addr = ptr; end
      ST_DAT_REQ: begin mem_rd = 1'b1; mem_addr = buf_q; end
      ST_WB:      begin mem_wr = 1'b1; mem_addr = ptr + AW'(CTL_OFS); mem_wdata = ctl_done(ctrl_q); end
      ST_ABT_WB:  begin mem_wr = 1'b1; mem_addr = ptr + AW'(CTL_OFS); mem_wdata = ctl_exhaust(ctrl_q); end
      default: ;
    endcase
  end

  // byte stream
  assign go       = (state_q != ST_IDLE);
  assign tx_valid = ser_valid || (state_q == ST_ABT_TX);
  assign tx_data  = (state_q == ST_ABT_TX) ? 8'h00 : ser_data;
  assign tx_err   = (state_q == ST_ABT_TX);
  assign tx_last  = tx_err || (ser_valid && remain_q == LEN_W'(1) && ctrl_q[EOF_BIT]);
  assign tx_nocrc = ser_valid && ctrl_q[NOCRC_BIT];

  assert_port_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_wb_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_wdata[USED_BIT]);
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> !tx_valid && !mem_wr);
  assert_used_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_used && !in_frame_q |=> !go);
  assert_abort_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_err |-> tx_last && tx_data == 8'h00 && !tx_nocrc);
  assert_abort_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abt_fire |=> !go);
  assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
endmodule

// File: tb/txring_dma_test.sv
module txring_dma_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int MEM_WORDS = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] ring_base = '0;
  logic base_wr = 1'b0, start = 1'b0, halt = 1'b0;
  logic go, mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic tx_valid, tx_last, tx_nocrc, tx_err;
  logic [7:0] tx_data;
  logic tx_ready;

  always #(CLK_PERIOD/2) clk = ~clk;

  txring_dma #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .base_wr(base_wr),
    .start(start), .halt(halt), .go(go), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_nocrc(tx_nocrc), .tx_err(tx_err), .tx_ready(tx_ready)
  );

  logic [31:0] mem [MEM_WORDS];
  logic [31:0] shadow [MEM_WORDS];

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[10:2]];
    if (mem_wr) mem[mem_addr[10:2]] <= mem_wdata;
  end

  int n_cmp = 0, n_bad = 0;
  bit running = 0, bp_mode = 0, done = 0;
  logic [15:0] lfsr = 16'hACE1;
  int m_ptr = 0, m_base = 0;

  int exp_byte[$], exp_last[$], exp_nocrc[$], exp_err[$];
  int exp_waddr[$], exp_wdata[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare every handshake and every memory write as it happens
  always @(negedge clk) begin
    if (!running) tx_ready = 1'b1;
    else begin
      if (bp_mode) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready = lfsr[0] | lfsr[3];
      end else tx_ready = 1'b1;
      if (tx_valid && tx_ready) begin
        if (exp_byte.size() == 0) chk("R2 unexpected byte", 32'd1, 32'd0);
        else begin
          chk("R2 byte", 32'(tx_data), 32'(exp_byte.pop_front()));
          chk("R3 last", 32'(tx_last), 32'(exp_last.pop_front()));
          chk("R4 nocrc", 32'(tx_nocrc), 32'(exp_nocrc.pop_front()));
          chk("R9 err", 32'(tx_err), 32'(exp_err.pop_front()));
        end
      end
      if (mem_wr) begin
        if (exp_waddr.size() == 0) chk("R5 unexpected write", 32'd1, 32'd0);
        else begin
          chk("R6 write address", mem_addr, 32'(exp_waddr.pop_front()));
          chk("R5 write data", mem_wdata, 32'(exp_wdata.pop_front()));
        end
      end
    end
  end

  // behavioural walk of the ring; halt_frames>0 stops after that many frames
  task automatic model(input int halt_frames);
    int frames = 0;
    bit inf = 0;
    for (int i = 0; i < MEM_WORDS; i++) shadow[i] = mem[i];
    forever begin
      logic [31:0] c, a, w;
      int len;
      if (halt_frames > 0 && frames >= halt_frames && !inf) break;
      c = shadow[(m_ptr + 4) / 4];
      if (c[31]) begin
        if (inf) begin
          exp_waddr.push_back(m_ptr + 4);
          exp_wdata.push_back(c | 32'h0800_0000);
          exp_byte.push_back(0); exp_last.push_back(1);
          exp_nocrc.push_back(0); exp_err.push_back(1);
        end
        break;
      end
      a = shadow[m_ptr / 4];
      len = int'(c & 32'h7FF);
      for (int i = 0; i < len; i++) begin
        w = shadow[(a + (i / 4) * 4) / 4];
        exp_byte.push_back(int'((w >> (8 * (i % 4))) & 32'hFF));
        exp_last.push_back((i == len - 1 && c[15]) ? 1 : 0);
        exp_nocrc.push_back(int'(c[16]));
        exp_err.push_back(0);
      end
      exp_waddr.push_back(m_ptr + 4);
      exp_wdata.push_back(c | 32'h8000_0000);
      shadow[(m_ptr + 4) / 4] = c | 32'h8000_0000;
      inf = !c[15];
      if (c[15]) frames++;
      m_ptr = c[30] ? m_base : m_ptr + 8;
    end
  endtask

  task automatic put_desc(input int at, input int addr, input int ctrl);
    mem[at / 4] = addr;
    mem[at / 4 + 1] = ctrl;
  endtask

  task automatic fill(input int addr, input int len);
    for (int i = 0; i < len; i++) begin
      int b = addr + i;
      mem[b / 4][8 * (b % 4) +: 8] = 8'((b * 13 + 5) & 255);
    end
  endtask

  task automatic load_base(input int b);
    @(negedge clk); ring_base = b; base_wr = 1'b1;
    @(negedge clk); base_wr = 1'b0;
    m_base = b; m_ptr = b;
  endtask

  task automatic kick(input int halt_after, input string req);
    int n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (halt_after > 0) begin
      repeat (halt_after - 1) @(negedge clk);
      halt = 1'b1; @(negedge clk); halt = 1'b0;
    end
    while (go && n < 20000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    chk({req, " bytes left"}, 32'(exp_byte.size()), 32'd0);
    chk({req, " writes left"}, 32'(exp_waddr.size()), 32'd0);
    chk({req, " go low"}, 32'(go), 32'd0);
    exp_byte.delete(); exp_last.delete(); exp_nocrc.delete(); exp_err.delete();
    exp_waddr.delete(); exp_wdata.delete();
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'h8000_0000;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 go", 32'(go), 32'd0);
    chk("R1 tx_valid", 32'(tx_valid), 32'd0);
    chk("R1 mem_rd", 32'(mem_rd), 32'd0);
    chk("R1 mem_wr", 32'(mem_wr), 32'd0);
    rst_n = 1'b1;
    running = 1;

    // R2 R3 R4 R7: three buffers from base 0, last one wrong length alignment
    put_desc(0,  32'h400, 32'h0000_0005);
    put_desc(8,  32'h420, 32'h0000_8003);
    put_desc(16, 32'h440, 32'h0001_8009);
    fill(32'h400, 5); fill(32'h420, 3); fill(32'h440, 9);
    model(0);
    kick(0, "R7 multi-buffer");

    // R12 R6: new base, wrap back to base, with backpressure (R11)
    load_base(32'h100);
    put_desc(32'h100, 32'h480, 32'h0000_8004);
    put_desc(32'h108, 32'h4A0, 32'h4000_8006);
    fill(32'h480, 4); fill(32'h4A0, 6);
    bp_mode = 1;
    model(0);
    kick(0, "R6 wrap");
    chk("R12 ring base used", mem[32'h104 / 4], 32'h8000_8004);

    // R8: start with first descriptor already used
    begin
      int hi = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int i = 0; i < 6; i++) begin if (go) hi++; @(negedge clk); end
      chk("R8 go cycles <= 3", 32'(hi <= 3), 32'd1);
      chk("R8 descriptor untouched", mem[32'h104 / 4], 32'h8000_8004);
    end

    // R9: descriptors run out mid-frame
    load_base(32'h40);
    put_desc(32'h40, 32'h500, 32'h0000_0006);
    put_desc(32'h48, 32'h000, 32'h8000_0000);
    fill(32'h500, 6);
    model(0);
    kick(0, "R9 exhausted");
    chk("R9 exhausted flag", mem[32'h4C / 4], 32'h8800_0000);

    // R10: halt during first frame, then resume
    load_base(32'h180);
    put_desc(32'h180, 32'h540, 32'h0000_8007);
    put_desc(32'h188, 32'h560, 32'h0001_8002);
    fill(32'h540, 7); fill(32'h560, 2);
    model(1);
    kick(3, "R10 halt");
    chk("R10 next untouched", mem[32'h18C / 4], 32'h0001_8002);
    model(0);
    kick(0, "R10 resume");

    // R2: long buffer with backpressure
    load_base(32'h1C0);
    put_desc(32'h1C0, 32'h600, 32'h0000_80C8);
    fill(32'h600, 200);
    model(0);
    kick(0, "R2 long");

    running = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule